// File: doc/BRIEF.md
# Parallel camera capture window packer

This block sits behind an 8-bit parallel pixel bus that carries a line sync and a frame sync, all in the pixel clock domain. It cuts a rectangular window out of each frame, measured in lines and in bytes, gathers the bytes inside that window four at a time into 32-bit words, and pushes each finished word into a receive FIFO through a write strobe. The FIFO itself lies outside the block; only its full indication comes back in.

Software-facing settings arrive as plain configuration inputs: a capture enable, the active level of each sync, the byte order inside a word, and the window placement and size. Four sticky status flags report the end of the window, a word lost to a full FIFO, and windows that the incoming frame was too short or too narrow to fill. Each flag has its own interrupt enable, and a one-cycle soft reset returns the whole capture path to idle.

Top module: `cam_window_packer`

## Requirements
- R1: Each sync input has its own polarity select; with the select at 0 the sync is active when the pin is high, with the select at 1 it is active when the pin is low.
- R2: A byte is captured only while both syncs are active, its line index (lines counted from 0 since the frame sync became active) lies in [line_first, line_first+line_total) and its byte index (counted from 0 since the line sync became active) lies in [byte_first, byte_first+byte_total).
- R3: Captured bytes are packed in arrival order into 32-bit words; with big_endian at 0 the first byte goes to bits 7:0 and the fourth to bits 31:24, with big_endian at 1 the first byte goes to bits 31:24 and the fourth to bits 7:0. Packing restarts at the first slot on every line and fewer than four bytes left at a line end are dropped.
- R4: Nothing is captured while run_en is 0. busy rises on the clock after the frame sync becomes active with run_en at 1 and falls on the clock after the frame sync becomes inactive or run_en goes to 0.
- R5: flags bit 0 (frame end) is set when the line sync goes inactive at the end of line index line_first+line_total-1 of a captured frame (line_total not 0).
- R6: flags bit 3 (horizontal error) is set when the line sync goes inactive on a line inside the vertical window after fewer than byte_first+byte_total bytes of that line.
- R7: flags bit 2 (vertical error) is set when the frame sync of a captured frame goes inactive after fewer than line_first+line_total completed lines.
- R8: A finished word that meets fifo_full at 1 is not written and sets flags bit 1 (overrun).
- R9: Flags are sticky; a flag_wr cycle clears each flag whose flag_wdata bit is 0 and leaves each flag whose bit is 1 untouched; a set event wins over a clear in the same cycle.
- R10: irq bit k is 1 exactly when flags bit k and irq_en bit k are both 1.
- R11: A soft_rst cycle clears all flags, busy, the packing position and the write strobe.
- R12: fifo_wr is high for exactly one cycle, the cycle after the clock edge that sampled the fourth byte of a word, with fifo_wdata holding that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_data | input | 8 | Pixel bus byte |
| hsync_in | input | 1 | Line sync pin |
| vsync_in | input | 1 | Frame sync pin |
| run_en | input | 1 | Capture enable |
| hsync_low | input | 1 | Line sync polarity: 1 = active low |
| vsync_low | input | 1 | Frame sync polarity: 1 = active low |
| big_endian | input | 1 | Byte order in a packed word |
| line_first | input | 12 | First captured line index |
| line_total | input | 12 | Number of captured lines |
| byte_first | input | 12 | First captured byte index in a line |
| byte_total | input | 12 | Number of captured bytes per line |
| soft_rst | input | 1 | One-cycle synchronous reset of the capture path |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 4 | Flag write data, 0 clears the matching flag |
| irq_en | input | 4 | Per-flag interrupt enables |
| fifo_full | input | 1 | Receive FIFO full |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_wdata | output | 32 | Packed word |
| busy | output | 1 | Frame reception in progress |
| flags | output | 4 | Sticky flags: 0 frame end, 1 overrun, 2 vertical error, 3 horizontal error |
| irq | output | 4 | Flag interrupts, gated by irq_en |

## Verification
Every result of this block is one register stage behind the clock edge that sees its cause: a packed word appears on the FIFO port the cycle after its fourth byte is sampled, a flag is visible the cycle after the sync edge or full condition that sets it, and busy follows the frame sync edge by one cycle. The bench drives all inputs on the falling clock edge and samples outputs on a falling edge, so each check reads the value settled after the rising edge in between. The strobe timing test counts falling edges one by one around the fourth byte, while whole-frame checks wait for trailing idle cycles before reading flags and the words collected by a falling-edge monitor.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  localparam int CNT_W     = 12;
  localparam int NUM_FLAGS = 4;
  localparam int FLG_FE    = 0;
  localparam int FLG_OVR   = 1;
  localparam int FLG_VERR  = 2;
  localparam int FLG_HERR  = 3;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [CNT_W:0]   ext_t;

  // end of a span, one bit wider so that start+size never wraps
  function automatic ext_t span_end(input cnt_t start, input cnt_t size);
    return {1'b0, start} + {1'b0, size};
  endfunction

  function automatic logic in_span(input ext_t idx, input cnt_t start, input cnt_t size);
    return (idx >= {1'b0, start}) && (idx < span_end(start, size));
  endfunction

  function automatic logic falls_short(input ext_t seen, input cnt_t start, input cnt_t size);
    return seen < span_end(start, size);
  endfunction
endpackage

// File: rtl/cwp_sync_track.sv
module cwp_sync_track
  import cwp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic run_en,
  input  logic hsync_in,
  input  logic vsync_in,
  input  logic hsync_low,
  input  logic vsync_low,
  input  cnt_t line_first,
  input  cnt_t line_total,
  input  cnt_t byte_first,
  input  cnt_t byte_total,
  output logic take,
  output logic line_open,
  output logic busy,
  output logic fe_evt,
  output logic herr_evt,
  output logic verr_evt
);
  localparam ext_t EXT_MAX = '1;

  logic hs_act, vs_act, hs_q, vs_q;
  logic vs_rise, vs_fall, hs_fall, sample;
  logic line_in_win;
  ext_t line_cnt, byte_cnt, byte_idx;

  assign hs_act  = hsync_in ^ hsync_low;
  assign vs_act  = vsync_in ^ vsync_low;
  assign vs_rise = vs_act & ~vs_q;
  assign vs_fall = ~vs_act & vs_q;
  assign line_open = hs_act & ~hs_q & vs_act;
  assign hs_fall = ~hs_act & hs_q & vs_act;
  assign sample  = hs_act & vs_act;
  assign byte_idx = line_open ? '0 : byte_cnt;

  assign line_in_win = in_span(line_cnt, line_first, line_total);
  assign take = busy & run_en & sample & line_in_win &
                in_span(byte_idx, byte_first, byte_total);

  assign fe_evt   = busy & hs_fall & (line_total != '0) &
                    (line_cnt == span_end(line_first, line_total) - ext_t'(1));
  assign herr_evt = busy & hs_fall & line_in_win &
                    falls_short(byte_cnt, byte_first, byte_total);
  assign verr_evt = busy & vs_fall & falls_short(line_cnt, line_first, line_total);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0; vs_q <= 1'b0; busy <= 1'b0;
      line_cnt <= '0; byte_cnt <= '0;
    end else if (soft_rst) begin
      hs_q <= 1'b0; vs_q <= 1'b0; busy <= 1'b0;
      line_cnt <= '0; byte_cnt <= '0;
    end else begin
      hs_q <= hs_act;
      vs_q <= vs_act;
      if (!run_en)      busy <= 1'b0;
      else if (vs_rise) busy <= 1'b1;
      else if (vs_fall) busy <= 1'b0;
      if (vs_rise)                             line_cnt <= '0;
      else if (hs_fall && line_cnt != EXT_MAX) line_cnt <= line_cnt + ext_t'(1);
      if (sample)
        byte_cnt <= (byte_idx == EXT_MAX) ? byte_idx : byte_idx + ext_t'(1);
    end
  end

  // busy only drops after a frame end, a stop or a soft reset
  assert_busy_drop_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(!run_en || vs_fall || soft_rst));
endmodule

// File: rtl/cwp_packer.sv
module cwp_packer #(
  parameter int DATA_W = 8,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    soft_rst,
  input  logic                    big_endian,
  input  logic                    line_open,
  input  logic                    take,
  input  logic [DATA_W-1:0]       pix,
  input  logic                    fifo_full,
  output logic                    fifo_wr,
  output logic [DATA_W*LANES-1:0] fifo_wdata,
  output logic                    ovr_evt
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int WORD_W = DATA_W * LANES;
  typedef logic [LANE_W-1:0] lane_t;
  localparam lane_t LAST = lane_t'(LANES - 1);

  lane_t lane_q, order, slot;
  logic  last;
  logic [WORD_W-1:0] word_q, word_next;

  assign order = line_open ? '0 : lane_q;
  assign slot  = big_endian ? (LAST - order) : order;
  assign last  = take && (order == LAST);
  assign ovr_evt = last & fifo_full;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word_next[g*DATA_W +: DATA_W] =
      (take && slot == lane_t'(g)) ? pix : word_q[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0; word_q <= '0; fifo_wr <= 1'b0; fifo_wdata <= '0;
    end else if (soft_rst) begin
      lane_q <= '0; word_q <= '0; fifo_wr <= 1'b0; fifo_wdata <= '0;
    end else begin
      if (take)           lane_q <= last ? '0 : order + lane_t'(1);
      else if (line_open) lane_q <= '0;
      word_q  <= word_next;
      fifo_wr <= last & ~fifo_full;
      if (last) fifo_wdata <= word_next;
    end
  end

  // a word reaches the FIFO only after a captured byte and only with room
  assert_store_needs_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> ($past(take) && !$past(fifo_full)));
  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |=> !fifo_wr || $past(take));
endmodule

// File: rtl/cwp_status.sv
module cwp_status #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [NF-1:0] set_evt,
  input  logic          flag_wr,
  input  logic [NF-1:0] flag_wdata,
  input  logic [NF-1:0] irq_en,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] irq
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flags[g] <= 1'b0;
      else if (soft_rst)                   flags[g] <= 1'b0;
      else if (set_evt[g])                 flags[g] <= 1'b1;
      else if (flag_wr && !flag_wdata[g])  flags[g] <= 1'b0;
    end
  end

  assign irq = flags & irq_en;

  // without a write or soft reset no flag ever drops
  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_wr && !soft_rst) |=> (($past(flags) & ~flags) == '0));
  assert_soft_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (flags == '0));
endmodule

// File: rtl/cam_window_packer.sv
module cam_window_packer
  import cwp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DATA_W-1:0]       pix_data,
  input  logic                    hsync_in,
  input  logic                    vsync_in,
  input  logic                    run_en,
  input  logic                    hsync_low,
  input  logic                    vsync_low,
  input  logic                    big_endian,
  input  logic [CNT_W-1:0]        line_first,
  input  logic [CNT_W-1:0]        line_total,
  input  logic [CNT_W-1:0]        byte_first,
  input  logic [CNT_W-1:0]        byte_total,
  input  logic                    soft_rst,
  input  logic                    flag_wr,
  input  logic [NUM_FLAGS-1:0]    flag_wdata,
  input  logic [NUM_FLAGS-1:0]    irq_en,
  input  logic                    fifo_full,
  output logic                    fifo_wr,
  output logic [DATA_W*LANES-1:0] fifo_wdata,
  output logic                    busy,
  output logic [NUM_FLAGS-1:0]    flags,
  output logic [NUM_FLAGS-1:0]    irq
);
  logic take, line_open, fe_evt, herr_evt, verr_evt, ovr_evt;
  logic [NUM_FLAGS-1:0] set_evt;

  cwp_sync_track u_track (
    .clk, .rst_n, .soft_rst, .run_en, .hsync_in, .vsync_in,
    .hsync_low, .vsync_low, .line_first, .line_total, .byte_first, .byte_total,
    .take, .line_open, .busy, .fe_evt, .herr_evt, .verr_evt
  );

  cwp_packer #(.DATA_W(DATA_W), .LANES(LANES)) u_pack (
    .clk, .rst_n, .soft_rst, .big_endian, .line_open, .take,
    .pix(pix_data), .fifo_full, .fifo_wr, .fifo_wdata, .ovr_evt
  );

  always_comb begin
    set_evt           = '0;
    set_evt[FLG_FE]   = fe_evt;
    set_evt[FLG_OVR]  = ovr_evt;
    set_evt[FLG_VERR] = verr_evt;
    set_evt[FLG_HERR] = herr_evt;
  end

  cwp_status #(.NF(NUM_FLAGS)) u_stat (
    .clk, .rst_n, .soft_rst, .set_evt, .flag_wr, .flag_wdata, .irq_en, .flags, .irq
  );

  assert_frame_end_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_evt && !soft_rst) |=> flags[FLG_FE]);
  assert_horizontal_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (herr_evt && !soft_rst) |=> flags[FLG_HERR]);
  assert_vertical_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (verr_evt && !soft_rst) |=> flags[FLG_VERR]);
  assert_idle_no_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(busy));
endmodule

// File: tb/tb_cam_window_packer.sv
module tb_cam_window_packer;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic be; logic hp; logic vp;
    logic [11:0] ls; logic [11:0] lc; logic [11:0] bs; logic [11:0] bw;
    logic [7:0] nl; logic [7:0] nb;
    logic fe; logic herr; logic verr;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0, 12'd1,12'd2,12'd2,12'd4, 8'd4,8'd8, 1'b1,1'b0,1'b0},
    '{1'b1,1'b1,1'b1, 12'd0,12'd3,12'd0,12'd8, 8'd3,8'd8, 1'b1,1'b0,1'b0},
    '{1'b0,1'b0,1'b1, 12'd2,12'd3,12'd1,12'd6, 8'd4,8'd8, 1'b0,1'b0,1'b1},
    '{1'b1,1'b1,1'b0, 12'd0,12'd2,12'd4,12'd8, 8'd2,8'd8, 1'b1,1'b1,1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic [7:0] pix_data = 0;
  logic hsync_in = 0, vsync_in = 0, run_en = 0, hsync_low = 0, vsync_low = 0, big_endian = 0;
  logic [11:0] line_first = 0, line_total = 0, byte_first = 0, byte_total = 0;
  logic soft_rst = 0, flag_wr = 0, fifo_full = 0;
  logic [3:0] flag_wdata = 0, irq_en = 0;
  logic fifo_wr, busy;
  logic [31:0] fifo_wdata;
  logic [3:0] flags, irq;

  int checks = 0, fails = 0, ncap = 0;
  logic done = 0;
  logic [31:0] cap [0:255];
  logic [31:0] expw [0:63];

  cam_window_packer dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (fifo_wr && ncap < 256) begin
    cap[ncap] = fifo_wdata; ncap = ncap + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] pix(input int row, input int l, input int b);
    return 8'((row * 40 + l * 16 + b) & 255);
  endfunction

  task automatic pulse_soft();
    soft_rst = 1; tick(); soft_rst = 0; tick();
  endtask

  task automatic apply_cfg(input vec_t v);
    big_endian = v.be; hsync_low = v.hp; vsync_low = v.vp;
    hsync_in = v.hp; vsync_in = v.vp;   // both syncs idle
    line_first = v.ls; line_total = v.lc; byte_first = v.bs; byte_total = v.bw;
    tick();
  endtask

  task automatic drive_frame(input vec_t v, input int row);
    vsync_in = ~v.vp; tick(2);
    for (int l = 0; l < int'(v.nl); l++) begin
      for (int b = 0; b < int'(v.nb); b++) begin
        hsync_in = ~v.hp; pix_data = pix(row, l, b); tick();
      end
      hsync_in = v.hp; tick(3);
    end
    vsync_in = v.vp; tick(4);
  endtask

  // independent model of window selection and packing: returns word count
  function automatic int model(input vec_t v, input int row);
    int n = 0;
    for (int l = 0; l < int'(v.nl); l++) begin
      logic [7:0] bq [4];
      int k = 0;
      if (l < int'(v.ls) || l >= int'(v.ls) + int'(v.lc)) continue;
      for (int b = 0; b < int'(v.nb); b++) begin
        if (b < int'(v.bs) || b >= int'(v.bs) + int'(v.bw)) continue;
        bq[k] = pix(row, l, b); k++;
        if (k == 4) begin
          expw[n] = v.be ? {bq[0], bq[1], bq[2], bq[3]} : {bq[3], bq[2], bq[1], bq[0]};
          n++; k = 0;
        end
      end
    end
    return n;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int base, n;
    tick(3); rst_n = 1; tick();
    // reset state (R11 idle values)
    chk("R11 reset fifo_wr", 32'(fifo_wr), 0);
    chk("R4 reset busy", 32'(busy), 0);
    chk("R9 reset flags", 32'(flags), 0);
    chk("R10 reset irq", 32'(irq), 0);

    // table of window/packing vectors (R1 R2 R3 R5 R6 R7 R10)
    run_en = 1; irq_en = 4'hF;
    for (int r = 0; r < NV; r++) begin
      pulse_soft();
      apply_cfg(VECS[r]);
      base = ncap;
      n = model(VECS[r], r);
      drive_frame(VECS[r], r);
      chk($sformatf("R2 row%0d word count", r), 32'(ncap - base), 32'(n));
      for (int i = 0; i < n; i++)
        chk($sformatf("R3 row%0d word%0d", r, i), cap[base + i], expw[i]);
      chk($sformatf("R5 row%0d frame end", r), 32'(flags[0]), 32'(VECS[r].fe));
      chk($sformatf("R6 row%0d horizontal error", r), 32'(flags[3]), 32'(VECS[r].herr));
      chk($sformatf("R7 row%0d vertical error", r), 32'(flags[2]), 32'(VECS[r].verr));
      chk($sformatf("R8 row%0d no overrun", r), 32'(flags[1]), 0);
      chk($sformatf("R10 row%0d irq", r), 32'(irq), 32'(flags));
      chk($sformatf("R4 row%0d busy after frame", r), 32'(busy), 0);
    end

    // R12 strobe timing, R1 active-high syncs, little-endian lanes
    pulse_soft();
    apply_cfg('{1'b0,1'b0,1'b0, 12'd0,12'd1,12'd0,12'd4, 8'd1,8'd4, 1'b1,1'b0,1'b0});
    vsync_in = 1; tick(2);
    hsync_in = 1;
    pix_data = 8'h11; tick(); pix_data = 8'h22; tick(); pix_data = 8'h33; tick();
    chk("R12 no strobe before fourth byte", 32'(fifo_wr), 0);
    pix_data = 8'h44; tick();
    chk("R12 strobe after fourth byte", 32'(fifo_wr), 1);
    chk("R12 word value", fifo_wdata, 32'h44332211);
    hsync_in = 0; tick();
    chk("R12 strobe one cycle", 32'(fifo_wr), 0);
    vsync_in = 0; tick(3);

    // R4 busy with active-low frame sync (R1)
    pulse_soft();
    vsync_low = 1; vsync_in = 1; hsync_low = 0; hsync_in = 0; tick(2);
    vsync_in = 0; tick(2);
    chk("R1 R4 busy with active-low frame sync", 32'(busy), 1);
    vsync_in = 1; tick(2);
    chk("R4 busy cleared at frame end", 32'(busy), 0);

    // R8 overrun: every word dropped, flag set
    pulse_soft();
    apply_cfg(VECS[0]);
    fifo_full = 1; base = ncap;
    drive_frame(VECS[0], 0);
    fifo_full = 0;
    chk("R8 no write while full", 32'(ncap - base), 0);
    chk("R8 overrun and frame end flags", 32'(flags), 32'h3);

    // R9 write 1 leaves flags, write 0 clears only that flag
    flag_wr = 1; flag_wdata = 4'hF; tick(); flag_wr = 0; tick();
    chk("R9 write of ones ignored", 32'(flags), 32'h3);
    flag_wr = 1; flag_wdata = 4'b1101; tick(); flag_wr = 0; tick();
    chk("R9 write zero clears overrun only", 32'(flags), 32'h1);

    // R10 interrupt gating
    irq_en = 4'b0010; tick();
    chk("R10 masked irq", 32'(irq), 0);
    irq_en = 4'b0001; tick();
    chk("R10 enabled irq", 32'(irq), 32'h1);

    // R11 soft reset clears flags
    pulse_soft();
    chk("R11 soft reset flags", 32'(flags), 0);
    chk("R11 soft reset irq", 32'(irq), 0);

    // R4 no capture when disabled
    run_en = 0; base = ncap;
    apply_cfg(VECS[0]);
    drive_frame(VECS[0], 0);
    chk("R4 no words when disabled", 32'(ncap - base), 0);
    chk("R4 no flags when disabled", 32'(flags), 0);
    chk("R4 not busy when disabled", 32'(busy), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule